// File: doc/BRIEF.md
# Operating-mode and direct-page register pair

This block holds two control registers on an 8-bit microcontroller register bus. The first is a one-bit operating-mode flag, where 0 means special single-chip and 1 means normal single-chip. The second is an 8-bit direct-page register that chooses which 256-byte page of the 64 KB space is reached by short-form addressing.

While reset is held, the mode flag tracks an external strap pin. It keeps the last sampled value when reset is released. After that, software may move the mode only in the permitted direction. A refused request sets a sticky lock. A security input masks every mode write.

The direct-page register can be rewritten without limit in special mode. In normal mode only the first write after reset takes effect. The block publishes the page as a 16-bit base address. It also flags whether a presented address falls inside that page, and this works the same under either memory-mapping scheme.

Top module: `mode_page_regs`

## Requirements
- R1: While rst_n is low, op_mode follows mode_pin at each clock. After release it keeps the last sampled pin value. The page register and mode_locked are 0 out of reset.
- R2: A write to offset 0x0B with wdata[7]=1 changes op_mode from 0 (special) to 1 (normal). A write that repeats the current value leaves op_mode as it is. No other event changes op_mode after reset.
- R3: A write to offset 0x0B with wdata[7]=0 while op_mode is 1 is refused. op_mode stays 1 and mode_locked goes high. mode_locked stays high until reset, and while it is high in normal mode all mode writes are ignored.
- R4: While secure is high, writes to offset 0x0B change neither op_mode nor mode_locked.
- R5: rdata is combinational from addr. Offset 0x0B reads {op_mode, 7'b0}, offset 0x11 reads the page register, and any other offset reads 0.
- R6: page_base equals {page register, 8'h00}. is_direct is high exactly when probe_addr[15:8] equals the page register.
- R7: Any write to offset 0x11 marks the page register as written. When op_mode is 1, a write to 0x11 updates the register only if it has not yet been marked since reset.
- R8: When op_mode is 0, every write to offset 0x11 loads wdata into the page register.
- R9: Writes to any offset other than 0x0B and 0x11 change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pin | input | 1 | External mode strap, sampled during reset |
| secure | input | 1 | High blocks all mode writes |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register offset for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| op_mode | output | 1 | Current mode: 0 special, 1 normal |
| mode_locked | output | 1 | Sticky flag set by a refused mode write |
| probe_addr | input | 16 | Address compared against the direct page |
| page_base | output | 16 | Direct-page base address |
| is_direct | output | 1 | probe_addr lies inside the direct page |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe sampled at the rising edge. They also assume that mode_pin only matters while rst_n is low, so no property checks op_mode against the pin after release. The bench drives every input on the falling edge, keeps wr_en high for exactly one cycle per access, and changes secure only between accesses. This keeps each write inside the conditions the properties expect.

// File: rtl/mode_page_regs.sv
module mode_page_regs #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  MODE_OFS = 8'h0B,
  parameter logic [7:0]  PAGE_OFS = 8'h11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_pin,
  input  logic            secure,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            op_mode,
  output logic            mode_locked,
  input  logic [2*DW-1:0] probe_addr,
  output logic [2*DW-1:0] page_base,
  output logic            is_direct
);
  logic          mode_q, lock_q, dp_done;
  logic [DW-1:0] dp_q;

  wire wr_mode = wr_en && (addr == AW'(MODE_OFS));
  wire wr_page = wr_en && (addr == AW'(PAGE_OFS));
  wire mode_go = wr_mode && !secure && !(lock_q && mode_q);
  wire req     = wdata[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_pin;
      lock_q  <= 1'b0;
      dp_q    <= '0;
      dp_done <= 1'b0;
    end else begin
      if (mode_go) begin
        if (mode_q && !req) lock_q <= 1'b1;
        else                mode_q <= req;
      end
      if (wr_page) begin
        dp_done <= 1'b1;
        if (!mode_q || !dp_done) dp_q <= wdata;
      end
    end
  end

  always_comb begin
    if (addr == AW'(MODE_OFS))      rdata = {mode_q, {(DW-1){1'b0}}};
    else if (addr == AW'(PAGE_OFS)) rdata = dp_q;
    else                            rdata = '0;
  end

  assign op_mode     = mode_q;
  assign mode_locked = lock_q;
  assign page_base   = {dp_q, {DW{1'b0}}};
  assign is_direct   = (probe_addr[2*DW-1:DW] == dp_q);
endmodule

module mode_page_regs_chk #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  MODE_OFS = 8'h0B,
  parameter logic [7:0]  PAGE_OFS = 8'h11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            secure,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rdata,
  input logic            op_mode,
  input logic            mode_locked,
  input logic            dp_done,
  input logic [2*DW-1:0] probe_addr,
  input logic [2*DW-1:0] page_base,
  input logic            is_direct
);
  AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(MODE_OFS)) |=> $stable(op_mode)); // R2
  AST_NORMAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode |=> op_mode); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> mode_locked); // R3
  AST_SECURE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (secure && wr_en && addr == AW'(MODE_OFS)) |=> ($stable(op_mode) && $stable(mode_locked))); // R4
  AST_MODE_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(MODE_OFS)) |-> (rdata[DW-2:0] == '0 && rdata[DW-1] == op_mode)); // R5
  AST_PAGE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    page_base[DW-1:0] == '0); // R6
  AST_DIRECT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    is_direct == (probe_addr[2*DW-1:DW] == page_base[2*DW-1:DW])); // R6
  AST_PAGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && dp_done) |=> $stable(page_base)); // R7
endmodule

bind mode_page_regs mode_page_regs_chk #(.AW(AW), .DW(DW), .MODE_OFS(MODE_OFS), .PAGE_OFS(PAGE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .secure(secure), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .op_mode(op_mode), .mode_locked(mode_locked), .dp_done(dp_done),
  .probe_addr(probe_addr), .page_base(page_base), .is_direct(is_direct)
);

// File: tb/sim_mode_page_regs.sv
module sim_mode_page_regs;
  logic        clk = 0, rst_n = 0, mode_pin = 0, secure = 0, wr_en = 0;
  logic [7:0]  addr = 0, wdata = 0, rdata;
  logic        op_mode, mode_locked, is_direct;
  logic [15:0] probe_addr = 0, page_base;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mode_page_regs u0 (.clk, .rst_n, .mode_pin, .secure, .wr_en, .addr, .wdata,
    .rdata, .op_mode, .mode_locked, .probe_addr, .page_base, .is_direct);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 8'hFF;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk); rst_n = 0; mode_pin = pin;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 0; mode_pin = 1;
    @(negedge clk); chk("R1", op_mode, 1);
    mode_pin = 0;
    @(negedge clk); chk("R1", op_mode, 0);
    mode_pin = 1;
    @(negedge clk); rst_n = 1; mode_pin = 0;
    repeat (2) @(negedge clk);
    chk("R1", op_mode, 1);
    chk("R1", page_base, 16'h0000);
    chk("R1", mode_locked, 0);
  endtask

  task automatic t_special;
    do_reset(0);
    wr(8'h11, 8'h12); chk("R8", page_base, 16'h1200);
    wr(8'h11, 8'h34); chk("R8", page_base, 16'h3400);
    rd("R5", 8'h11, 8'h34);
    wr(8'h0B, 8'h00); chk("R2", op_mode, 0);
    rd("R5", 8'h0B, 8'h00);
    wr(8'h0B, 8'h80); chk("R2", op_mode, 1);
    rd("R5", 8'h0B, 8'h80);
    wr(8'h11, 8'h56); chk("R7", page_base, 16'h3400);
  endtask

  task automatic t_normal;
    do_reset(1);
    wr(8'h11, 8'hA5); chk("R7", page_base, 16'hA500);
    wr(8'h11, 8'h5A); chk("R7", page_base, 16'hA500);
    probe_addr = 16'hA57E; #1; chk("R6", is_direct, 1);
    probe_addr = 16'h5A00; #1; chk("R6", is_direct, 0);
    probe_addr = 16'hA4FF; #1; chk("R6", is_direct, 0);
    wr(8'h0B, 8'h80); chk("R2", op_mode, 1); chk("R2", mode_locked, 0);
    wr(8'h0B, 8'h00); chk("R3", op_mode, 1); chk("R3", mode_locked, 1);
    wr(8'h0B, 8'h00); chk("R3", op_mode, 1); chk("R3", mode_locked, 1);
    do_reset(0); @(negedge clk);
    chk("R3", mode_locked, 0);
  endtask

  task automatic t_secure;
    do_reset(0);
    secure = 1;
    wr(8'h0B, 8'h80); chk("R4", op_mode, 0);
    secure = 0;
    wr(8'h0B, 8'h80); chk("R4", op_mode, 1);
    do_reset(1);
    secure = 1;
    wr(8'h0B, 8'h00); chk("R4", op_mode, 1); chk("R4", mode_locked, 0);
    secure = 0;
  endtask

  task automatic t_other;
    do_reset(0);
    wr(8'h0C, 8'h80); chk("R9", op_mode, 0);
    wr(8'h10, 8'h77); chk("R9", page_base, 16'h0000);
    wr(8'h11, 8'h09); chk("R9", page_base, 16'h0900);
    rd("R5", 8'h0C, 8'h00);
    rd("R5", 8'h10, 8'h00);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset;
    t_special;
    t_normal;
    t_secure;
    t_other;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run;
  end
endmodule